// File: doc/BRIEF.md
# SPI Command and Register Decoder

This block is the host-facing front end of a serial avionics bus interface. A host processor talks to it over a four-wire SPI link in mode 0, most significant bit first. Each frame starts when chip select goes low. The first eight bits form an opcode. Data bits may follow, either shifted in by the host or shifted out by the block. The block holds a 16-bit control register and a 256-entry label-enable table. It sends control, status and received-word contents back on the serial output. It also issues single-cycle strobes toward the transmit and receive datapaths.

The SPI pins are sampled in the system clock domain, so SCK must run well below the system clock. Action commands take effect on the last serial input bit of the command, while chip select is still low. A frame that chip select cuts short leaves no trace. The serial output is presented as a data bit plus an output enable for the pad. The datapath reads the label table one entry at a time through a lookup port.

Top module: `spi_cmd_decoder`

## Requirements
- R1: After reset the control register and every label-enable entry are 0, all strobes are low and the serial output enable is low.
- R2: The serial output enable is low whenever chip select is high, and high for the whole of a frame.
- R3: Opcode 0x10 followed by 16 bits loads the control register, first bit into bit 15. The new value appears on `ctrl_o` only after the 16th data bit.
- R4: Opcode 0x0B shifts the control register out MSB first. Its first bit is valid after the SCK falling edge that follows the eighth rising edge.
- R5: Opcode 0x0E followed by 256 bits loads the label table, first bit into entry 255. Opcode 0x0D shifts the table out in the same order: entry 255 first.
- R6: Opcode 0x11 pulses `tx_clr_o` for one clock right after its eighth bit is sampled, before chip select rises.
- R7: Opcode 0x12 pulses `tx_go_o` in the same way, but only when control bit 13 is 0. When that bit is 1, the command has no effect.
- R8: Opcode 0x08 shifts out the 32-bit received word, MSB first. Opcode 0x09 shifts out its upper 16 bits. Each pulses `rx_pop_o` once, after its last data bit.
- R9: Opcode 0x0A shifts out the 8-bit status input, MSB first.
- R10: A frame ended by chip select before its last bit changes no register or table entry and issues no strobe.
- R11: Any opcode not listed above shifts out zeros and changes no state. Bits clocked past the end of any read payload are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| si | input | 1 | SPI serial data from the host |
| so_o | output | 1 | SPI serial data to the host |
| so_oe_o | output | 1 | Output enable for the serial output pad |
| rx_word_i | input | RX_W | Oldest received bus word |
| status_i | input | ST_W | Status flags from the datapath |
| lbl_addr_i | input | log2(LBL_N) | Label table lookup address |
| lbl_hit_o | output | 1 | Enable bit of the addressed label |
| ctrl_o | output | CR_W | Control register contents |
| tx_clr_o | output | 1 | Strobe: clear the transmit FIFO |
| tx_go_o | output | 1 | Strobe: start transmission |
| rx_pop_o | output | 1 | Strobe: a received word was read |

## Verification
A bit counter that is off by one shows up on the very first readback. The returned control or label bits come back shifted by one position, and this is visible on the same frame. A corrupted control register or label entry appears on `ctrl_o` or at the lookup port one clock after the last data bit. A wrong opcode latch shows as a strobe that is missing or extra, about two clocks after the deciding SCK edge and before chip select rises. It can also show as nonzero data from an opcode that should return zeros.

// File: rtl/spi_dec_pkg.sv
// Shared opcode values and fixed field positions for the SPI command decoder.
// Assumes an 8-bit opcode leads every frame.
package spi_dec_pkg;
    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OP_RD_RX  = 8'h08;
    localparam logic [OPC_W-1:0] OP_RD_RXH = 8'h09;
    localparam logic [OPC_W-1:0] OP_RD_ST  = 8'h0A;
    localparam logic [OPC_W-1:0] OP_RD_CR  = 8'h0B;
    localparam logic [OPC_W-1:0] OP_RD_LBL = 8'h0D;
    localparam logic [OPC_W-1:0] OP_WR_LBL = 8'h0E;
    localparam logic [OPC_W-1:0] OP_WR_CR  = 8'h10;
    localparam logic [OPC_W-1:0] OP_TX_CLR = 8'h11;
    localparam logic [OPC_W-1:0] OP_TX_GO  = 8'h12;

    // Control bit that, when set, blocks the start-transmission command.
    localparam int GO_HOLD_BIT = 13;
endpackage

// File: rtl/spi_pin_sampler.sv
// Samples the SPI pins in the system clock domain and finds SCK edges.
// Assumes the pins are already synchronous to clk and that SCK stays in
// each level for at least two clk cycles.
module spi_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic cs_act,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);
    logic sck_d1, sck_d2;

    // Register the pins and keep one extra SCK stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d1 <= 1'b0;
            sck_d2 <= 1'b0;
            cs_act <= 1'b0;
            si_s   <= 1'b0;
        end else begin
            sck_d1 <= sck;
            sck_d2 <= sck_d1;
            cs_act <= ~cs_n;
            si_s   <= si;
        end
    end

    assign sck_rise = cs_act & sck_d1 & ~sck_d2;
    assign sck_fall = cs_act & ~sck_d1 & sck_d2;
endmodule

// File: rtl/spi_frame_ctr.sv
// Counts SCK rising edges within a frame and captures the opcode.
// Assumes cs_act low clears the frame; the count saturates at its maximum.
module spi_frame_ctr
    import spi_dec_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_act,
    input  logic             sck_rise,
    input  logic             si_s,
    output logic [CNT_W-1:0] cnt,
    output logic [OPC_W-1:0] opc_q,
    output logic [OPC_W-1:0] opc_now
);
    // Opcode value including the bit being sampled now.
    assign opc_now = {opc_q[OPC_W-2:0], si_s};

    // Advance the bit count and shift in opcode bits during the first byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            cnt   <= '0;
            opc_q <= '0;
        end else if (sck_rise) begin
            if (cnt != '1)
                cnt <= cnt + 1'b1;
            if (cnt < CNT_W'(OPC_W))
                opc_q <= opc_now;
        end
    end

    // R10
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (cnt == '0));
endmodule

// File: rtl/spi_cmd_exec.sv
// Executes commands: owns the control register and label table and emits
// datapath strobes. Writes commit only on the final data bit of the frame.
// Assumes cnt holds the index of the bit sampled on bit_stb.
module spi_cmd_exec
    import spi_dec_pkg::*;
#(
    parameter int CR_W  = 16,
    parameter int LBL_N = 256,
    parameter int RX_W  = 32,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             bit_val,
    input  logic [CNT_W-1:0] cnt,
    input  logic [OPC_W-1:0] opc_q,
    input  logic [OPC_W-1:0] opc_now,
    output logic [CR_W-1:0]  ctrl_q,
    output logic [LBL_N-1:0] lbl_q,
    output logic             tx_clr_o,
    output logic             tx_go_o,
    output logic             rx_pop_o
);
    localparam int SH_W = (LBL_N > CR_W) ? LBL_N : CR_W;

    logic [SH_W-1:0]  shadow;
    logic [CNT_W-1:0] didx;
    logic             in_data;
    logic             last_op;

    assign didx    = cnt - CNT_W'(OPC_W);
    assign in_data = cnt >= CNT_W'(OPC_W);
    assign last_op = cnt == CNT_W'(OPC_W - 1);

    // Decode each sampled bit: action strobes, shadow shifting and commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            lbl_q    <= '0;
            shadow   <= '0;
            tx_clr_o <= 1'b0;
            tx_go_o  <= 1'b0;
            rx_pop_o <= 1'b0;
        end else begin
            tx_clr_o <= 1'b0;
            tx_go_o  <= 1'b0;
            rx_pop_o <= 1'b0;
            if (bit_stb && last_op) begin
                if (opc_now == OP_TX_CLR)
                    tx_clr_o <= 1'b1;
                if (opc_now == OP_TX_GO && !ctrl_q[GO_HOLD_BIT])
                    tx_go_o <= 1'b1;
            end
            if (bit_stb && in_data) begin
                case (opc_q)
                    OP_WR_CR: begin
                        shadow <= {shadow[SH_W-2:0], bit_val};
                        if (didx == CNT_W'(CR_W - 1))
                            ctrl_q <= {shadow[CR_W-2:0], bit_val};
                    end
                    OP_WR_LBL: begin
                        shadow <= {shadow[SH_W-2:0], bit_val};
                        if (didx == CNT_W'(LBL_N - 1))
                            lbl_q <= {shadow[LBL_N-2:0], bit_val};
                    end
                    OP_RD_RX: begin
                        if (didx == CNT_W'(RX_W - 1))
                            rx_pop_o <= 1'b1;
                    end
                    OP_RD_RXH: begin
                        if (didx == CNT_W'(RX_W / 2 - 1))
                            rx_pop_o <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_clr_o, tx_go_o, rx_pop_o}));

    // R7
    go_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go_o |-> !ctrl_q[GO_HOLD_BIT]);

    // R3
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_stb && in_data && opc_q == OP_WR_CR) |=> $stable(ctrl_q));
endmodule

// File: rtl/spi_so_mux.sv
// Selects the next serial output bit for read commands and updates it on
// SCK falling edges (mode 0). Receive and status reads use a snapshot taken
// when the opcode completes. Assumes ST_W <= RX_W.
module spi_so_mux
    import spi_dec_pkg::*;
#(
    parameter int CR_W  = 16,
    parameter int LBL_N = 256,
    parameter int RX_W  = 32,
    parameter int ST_W  = 8,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_act,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  logic [CNT_W-1:0] cnt,
    input  logic [OPC_W-1:0] opc_q,
    input  logic [OPC_W-1:0] opc_now,
    input  logic [CR_W-1:0]  ctrl_q,
    input  logic [LBL_N-1:0] lbl_q,
    input  logic [RX_W-1:0]  rx_word_i,
    input  logic [ST_W-1:0]  status_i,
    output logic             so_q
);
    localparam int CR_AW  = $clog2(CR_W);
    localparam int LBL_AW = $clog2(LBL_N);
    localparam int RX_AW  = $clog2(RX_W);

    logic [RX_W-1:0]  snap;
    logic [CNT_W-1:0] k;
    logic             nxt;
    logic             is_rd;

    assign k     = cnt - CNT_W'(OPC_W);
    assign is_rd = opc_q inside {OP_RD_RX, OP_RD_RXH, OP_RD_ST, OP_RD_CR, OP_RD_LBL};

    // Freeze the received word or status at the end of the opcode byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap <= '0;
        else if (sck_rise && cnt == CNT_W'(OPC_W - 1)) begin
            if (opc_now == OP_RD_ST)
                snap <= RX_W'(status_i) << (RX_W - ST_W);
            else
                snap <= rx_word_i;
        end
    end

    // Pick payload bit k for the latched opcode, zero past the payload end.
    always_comb begin
        nxt = 1'b0;
        if (cnt >= CNT_W'(OPC_W)) begin
            case (opc_q)
                OP_RD_CR:  if (k < CNT_W'(CR_W))
                               nxt = ctrl_q[CR_AW'(CR_W - 1) - k[CR_AW-1:0]];
                OP_RD_LBL: if (k < CNT_W'(LBL_N))
                               nxt = lbl_q[LBL_AW'(LBL_N - 1) - k[LBL_AW-1:0]];
                OP_RD_RX:  if (k < CNT_W'(RX_W))
                               nxt = snap[RX_AW'(RX_W - 1) - k[RX_AW-1:0]];
                OP_RD_RXH: if (k < CNT_W'(RX_W / 2))
                               nxt = snap[RX_AW'(RX_W - 1) - k[RX_AW-1:0]];
                OP_RD_ST:  if (k < CNT_W'(ST_W))
                               nxt = snap[RX_AW'(RX_W - 1) - k[RX_AW-1:0]];
                default:   nxt = 1'b0;
            endcase
        end
    end

    // Present the selected bit after each SCK falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act)
            so_q <= 1'b0;
        else if (sck_fall)
            so_q <= nxt;
    end

    // R11
    unknown_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && cnt >= CNT_W'(OPC_W) && !is_rd) |=> !so_q);
endmodule

// File: rtl/spi_cmd_decoder.sv
// Top of the SPI command decoder: pin sampling, frame counting, command
// execution and serial output selection. Assumes SPI pins synchronous to
// clk with SCK much slower than clk.
module spi_cmd_decoder
    import spi_dec_pkg::*;
#(
    parameter int CR_W  = 16,
    parameter int LBL_N = 256,
    parameter int RX_W  = 32,
    parameter int ST_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sck,
    input  logic                     cs_n,
    input  logic                     si,
    output logic                     so_o,
    output logic                     so_oe_o,
    input  logic [RX_W-1:0]          rx_word_i,
    input  logic [ST_W-1:0]          status_i,
    input  logic [$clog2(LBL_N)-1:0] lbl_addr_i,
    output logic                     lbl_hit_o,
    output logic [CR_W-1:0]          ctrl_o,
    output logic                     tx_clr_o,
    output logic                     tx_go_o,
    output logic                     rx_pop_o
);
    localparam int CNT_W = $clog2(OPC_W + LBL_N + 1);

    logic             cs_act, sck_rise, sck_fall, si_s, so_q;
    logic [CNT_W-1:0] cnt;
    logic [OPC_W-1:0] opc_q, opc_now;
    logic [CR_W-1:0]  ctrl_q;
    logic [LBL_N-1:0] lbl_q;

    spi_pin_sampler u_pins (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .cs_act(cs_act), .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s)
    );

    spi_frame_ctr #(.CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
        .si_s(si_s), .cnt(cnt), .opc_q(opc_q), .opc_now(opc_now)
    );

    spi_cmd_exec #(.CR_W(CR_W), .LBL_N(LBL_N), .RX_W(RX_W), .CNT_W(CNT_W)) u_exec (
        .clk(clk), .rst_n(rst_n), .bit_stb(sck_rise), .bit_val(si_s),
        .cnt(cnt), .opc_q(opc_q), .opc_now(opc_now), .ctrl_q(ctrl_q),
        .lbl_q(lbl_q), .tx_clr_o(tx_clr_o), .tx_go_o(tx_go_o), .rx_pop_o(rx_pop_o)
    );

    spi_so_mux #(.CR_W(CR_W), .LBL_N(LBL_N), .RX_W(RX_W), .ST_W(ST_W), .CNT_W(CNT_W)) u_so (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .cnt(cnt), .opc_q(opc_q), .opc_now(opc_now),
        .ctrl_q(ctrl_q), .lbl_q(lbl_q), .rx_word_i(rx_word_i),
        .status_i(status_i), .so_q(so_q)
    );

    assign so_o      = so_q;
    assign so_oe_o   = cs_act;
    assign ctrl_o    = ctrl_q;
    assign lbl_hit_o = lbl_q[lbl_addr_i];

    // R2
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !so_oe_o);
endmodule

// File: tb/tb_spi_cmd_decoder.sv
`timescale 1ns/1ps
module tb_spi_cmd_decoder;
    localparam int HALF = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic         so_o, so_oe_o, lbl_hit_o, tx_clr_o, tx_go_o, rx_pop_o;
    logic [31:0]  rx_word_i = '0;
    logic [7:0]   status_i = '0;
    logic [7:0]   lbl_addr_i = '0;
    logic [15:0]  ctrl_o;

    int checks = 0, errors = 0;
    int n_clr = 0, n_go = 0, n_pop = 0;
    int p_clr, p_go, p_pop;
    logic [255:0] dout;
    logic [255:0] lpat;
    bit           oe_gap;

    always #2 clk = ~clk;

    spi_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so_o(so_o), .so_oe_o(so_oe_o), .rx_word_i(rx_word_i),
        .status_i(status_i), .lbl_addr_i(lbl_addr_i), .lbl_hit_o(lbl_hit_o),
        .ctrl_o(ctrl_o), .tx_clr_o(tx_clr_o), .tx_go_o(tx_go_o), .rx_pop_o(rx_pop_o)
    );

    always @(negedge clk) begin
        if (tx_clr_o) n_clr++;
        if (tx_go_o)  n_go++;
        if (rx_pop_o) n_pop++;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One SPI frame: nop opcode bits, then nd data bits from din (MSB first).
    task automatic frame(input logic [7:0] op, input int nop, input int nd,
                         input logic [255:0] din);
        dout = '0;
        oe_gap = 1'b0;
        cs_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < nop + nd; i++) begin
            si = (i < 8) ? op[7-i] : din[nd-1-(i-8)];
            tick(HALF);
            if (so_oe_o !== 1'b1) oe_gap = 1'b1;
            if (i >= 8) dout = {dout[254:0], so_o};
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
        tick(HALF);
        p_clr = n_clr; p_go = n_go; p_pop = n_pop;
        cs_n = 1'b1;
        si = 1'b0;
        tick(2 * HALF);
    endtask

    function automatic bit is_known(input logic [7:0] op);
        return op inside {8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0D, 8'h0E, 8'h10, 8'h11, 8'h12};
    endfunction

    task automatic wr_ctrl(input logic [15:0] v);
        frame(8'h10, 8, 16, 256'(v));
    endtask

    task automatic label_sweep(input logic [255:0] exp, input string req);
        for (int a = 0; a < 256; a++) begin
            lbl_addr_i = 8'(a);
            #1;
            check(lbl_hit_o == exp[a], req, 256'(lbl_hit_o), 256'(exp[a]));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [15:0] pats[18];
        logic [31:0] rxs[3];
        logic [7:0]  sts[3];
        int g0, c0, q0;
        logic [15:0] keep;

        tick(5);
        rst_n = 1'b1;
        tick(3);

        // R1 reset state
        check(ctrl_o == 16'h0, "R1", 256'(ctrl_o), 0);
        check(so_oe_o == 1'b0, "R1", 256'(so_oe_o), 0);
        check(n_clr + n_go + n_pop == 0, "R1", 256'(n_clr + n_go + n_pop), 0);
        label_sweep('0, "R1");

        // R3 / R4 / R2 control write and readback sweep
        for (int b = 0; b < 16; b++) pats[b] = 16'(1) << b;
        pats[16] = 16'hFFFF;
        pats[17] = 16'h5A3C;
        for (int p = 0; p < 18; p++) begin
            wr_ctrl(pats[p]);
            check(ctrl_o == pats[p], "R3", 256'(ctrl_o), 256'(pats[p]));
            check(!oe_gap, "R2", 256'(oe_gap), 0);
            frame(8'h0B, 8, 16, '0);
            check(dout[15:0] == pats[p], "R4", 256'(dout[15:0]), 256'(pats[p]));
            check(so_oe_o == 1'b0, "R2", 256'(so_oe_o), 0);
        end

        // R6 transmit FIFO clear
        wr_ctrl(16'h0000);
        c0 = n_clr; g0 = n_go;
        frame(8'h11, 8, 0, '0);
        check(p_clr - c0 == 1, "R6", 256'(p_clr - c0), 1);
        check(n_go == g0, "R6", 256'(n_go - g0), 0);

        // R7 transmit start, gated by control bit 13
        g0 = n_go;
        frame(8'h12, 8, 0, '0);
        check(p_go - g0 == 1, "R7", 256'(p_go - g0), 1);
        wr_ctrl(16'h2000);
        g0 = n_go;
        frame(8'h12, 8, 0, '0);
        check(n_go == g0, "R7", 256'(n_go - g0), 0);
        check(ctrl_o == 16'h2000, "R7", 256'(ctrl_o), 256'(16'h2000));
        wr_ctrl(16'hDFFF);
        g0 = n_go;
        frame(8'h12, 8, 0, '0);
        check(p_go - g0 == 1, "R7", 256'(p_go - g0), 1);

        // R5 label table write, lookup and readback
        for (int l = 0; l < 256; l++) lpat[l] = (((l * 7) + (l >> 3)) % 3) == 0;
        frame(8'h0E, 8, 256, lpat);
        label_sweep(lpat, "R5");
        frame(8'h0D, 8, 256, '0);
        check(dout == lpat, "R5", dout, lpat);

        // R10 partial frames leave no trace
        frame(8'h0E, 8, 100, ~lpat);
        label_sweep(lpat, "R10");
        keep = ctrl_o;
        frame(8'h10, 8, 10, 256'(16'h1234));
        check(ctrl_o == keep, "R10", 256'(ctrl_o), 256'(keep));
        c0 = n_clr;
        frame(8'h11, 5, 0, '0);
        check(n_clr == c0, "R10", 256'(n_clr - c0), 0);

        // R8 received word reads
        rxs[0] = 32'hC3A5_1E70; rxs[1] = 32'h8000_0001; rxs[2] = 32'h7FFE_F00D;
        for (int r = 0; r < 3; r++) begin
            rx_word_i = rxs[r];
            q0 = n_pop;
            frame(8'h08, 8, 32, '0);
            check(dout[31:0] == rxs[r], "R8", 256'(dout[31:0]), 256'(rxs[r]));
            check(p_pop - q0 == 1, "R8", 256'(p_pop - q0), 1);
            q0 = n_pop;
            frame(8'h09, 8, 16, '0);
            check(dout[15:0] == rxs[r][31:16], "R8", 256'(dout[15:0]), 256'(rxs[r][31:16]));
            check(p_pop - q0 == 1, "R8", 256'(p_pop - q0), 1);
        end
        q0 = n_pop;
        frame(8'h08, 8, 20, '0);
        check(n_pop == q0, "R10", 256'(n_pop - q0), 0);

        // R9 status read, R11 trailing bits are zero
        sts[0] = 8'hA5; sts[1] = 8'h01; sts[2] = 8'hFF;
        for (int s = 0; s < 3; s++) begin
            status_i = sts[s];
            frame(8'h0A, 8, 12, '0);
            check(dout[11:4] == sts[s], "R9", 256'(dout[11:4]), 256'(sts[s]));
            check(dout[3:0] == 4'h0, "R11", 256'(dout[3:0]), 0);
        end

        // R11 every unlisted opcode returns zeros and changes nothing
        keep = ctrl_o;
        for (int op = 0; op < 256; op++) begin
            if (!is_known(8'(op))) begin
                c0 = n_clr; g0 = n_go; q0 = n_pop;
                frame(8'(op), 8, 16, '1);
                check(dout[15:0] == 16'h0 && ctrl_o == keep &&
                      n_clr == c0 && n_go == g0 && n_pop == q0,
                      "R11", {dout[15:0], ctrl_o}, {16'h0, keep});
            end
        end
        label_sweep(lpat, "R11");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule